// File: doc/BRIEF.md
# Bus-Serviced Watchdog Timer

This block is a watchdog counter that runs on a clock four times the CPU bus rate. Software has to service it at regular intervals. If it does not, the counter reaches its limit and the block requests a system reset. It sits on a plain 8-bit CPU bus.

Software services the watchdog by writing to the highest address of the memory map. The data value does not matter. That same address also holds the low byte of the reset vector. A read there returns that vector byte, which comes in on an input port, and never exposes any watchdog state.

A configuration input selects a long or a short timeout. Mode inputs apply the processor's operating rules:
- In wait mode the watchdog keeps running.
- In stop mode its clock is removed and its count is lost.
- It is suppressed while the monitor is active with the test voltage present.
- It is also suppressed during a monitor-mode break when the break-disable bit is set.

Besides the one-clock reset request, the block keeps a sticky flag that records a watchdog-caused reset. Only power-on reset clears that flag. The block has no interrupt output.

Top module: `watchdog_guard`

## Requirements
- R1: A bus write with any data to address 0xFFFF returns the count to zero, so the next timeout comes a full period after that write.
- R2: A bus write to any address other than 0xFFFF has no effect on the count or on the timeout timing.
- R3: A bus read of 0xFFFF returns `vec_lo` on `bus_rdata` in the same cycle. A read of any other address returns 0x00. No read changes the count.
- R4: With `rate_sel` = 0 the timeout comes after LONG_LEN uninterrupted counting clocks. With `rate_sel` = 1 it comes after SHORT_LEN clocks.
- R5: On timeout, `wdg_rst_req` is high for exactly one clock, and counting restarts from zero.
- R6: `wdg_rst_flag` goes high with the first timeout. It stays high until `por_n` is low. `sys_rst` does not clear it.
- R7: While `sys_rst` is high the count is held at zero, and counting restarts from zero when it is released. After power-on reset, the request and the flag are low.
- R8: Wait mode (`wait_mode` = 1) does not pause counting, so a timeout during wait still raises the request.
- R9: While `stop_mode` = 1 the count is held at zero and no request is raised. After stop ends, a full timeout period is needed.
- R10: While `mon_mode` = 1 and `tst_volt` = 1 the watchdog is off: count held at zero, no request. Either input alone does not turn it off.
- R11: While `brk_act` = 1, `mon_mode` = 1 and `brk_dis` = 1 the watchdog is off. A break with `brk_dis` = 0 leaves it running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Four-times bus clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst | input | 1 | System reset, synchronous, clears the count |
| bus_addr | input | 16 | CPU bus address |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | 8 | Bus write data (value ignored) |
| bus_rdata | output | 8 | Bus read data |
| vec_lo | input | 8 | Low byte of the reset vector |
| rate_sel | input | 1 | 0 selects the long timeout, 1 the short one |
| mon_mode | input | 1 | Monitor mode active |
| tst_volt | input | 1 | Test voltage present on the interrupt pin |
| wait_mode | input | 1 | Wait standby mode |
| stop_mode | input | 1 | Stop standby mode |
| brk_act | input | 1 | Break interrupt in progress |
| brk_dis | input | 1 | Break-disable bit for the watchdog |
| wdg_rst_req | output | 1 | One-clock reset request on timeout |
| wdg_rst_flag | output | 1 | Sticky flag: the last reset came from the watchdog |

## Verification
The hardest conditions to reach from the ports are a timeout at the exact expiry clock and suppression that must hold through a window longer than a whole timeout. The count is never visible, so both can only be seen through the timing of the reset request.

The bench uses shortened lengths so that full periods fit in a run. Directed phases hold stop, monitor and break conditions for longer than the short period and then check that the next request comes exactly one period after release. A long random phase then mixes services, wrong-address writes, reads, mode pulses and resets. A cycle-accurate model predicts every request edge throughout.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   localparam int unsigned BUS_AW = 16;
   localparam int unsigned BUS_DW = 8;
   localparam logic [BUS_AW-1:0] SVC_ADDR = 16'hFFFF;

   typedef struct packed {
      logic mon;
      logic tst;
      logic wt;
      logic stp;
      logic brk;
      logic bdis;
   } wdg_mode_t;
endpackage

// File: rtl/wdg_bus.sv
module wdg_bus
   import wdg_pkg::*;
#(
   parameter int unsigned AW     = BUS_AW,
   parameter int unsigned DW     = BUS_DW,
   parameter logic [AW-1:0] ADDR = SVC_ADDR,
   parameter bit RD_REG          = 1'b0
)(
   input  logic          clk,
   input  logic          por_n,
   input  logic [AW-1:0] addr,
   input  logic          wr,
   input  logic          rd,
   input  logic [DW-1:0] vec,
   output logic [DW-1:0] rdata,
   output logic          svc
);
   logic hit;
   logic [DW-1:0] rd_next;

   assign hit     = (addr == ADDR);
   assign svc     = wr & hit;
   assign rd_next = (rd & hit) ? vec : '0;

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) rdata <= '0;
            else        rdata <= rd_next;
         end
      end else begin : g_rd_comb
         assign rdata = rd_next;
         always_comb begin
            if (por_n && rd && hit)
               AST_VEC_READ: assert (rdata == vec); // R3
         end
      end
   endgenerate
endmodule

// File: rtl/wdg_gate.sv
module wdg_gate
   import wdg_pkg::*;
(
   input  wdg_mode_t mode,
   input  logic      sys_rst,
   input  logic      svc,
   output logic      off,
   output logic      clr
);
   logic tst_off;
   logic brk_off;

   assign tst_off = mode.mon & mode.tst;
   assign brk_off = mode.brk & mode.mon & mode.bdis;
   assign off     = tst_off | brk_off;
   // wait mode (mode.wt) intentionally leaves counting alone
   assign clr     = off | mode.stp | sys_rst | svc;
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
   parameter int unsigned LONG_LEN  = 262128,
   parameter int unsigned SHORT_LEN = 8176
)(
   input  logic clk,
   input  logic por_n,
   input  logic clr,
   input  logic rate_sel,
   output logic req,
   output logic flag
);
   localparam int unsigned CW = $clog2(LONG_LEN);
   localparam logic [CW-1:0] LONG_M1  = CW'(LONG_LEN - 1);
   localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_LEN - 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim_m1;

   assign lim_m1 = rate_sel ? SHORT_M1 : LONG_M1;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt  <= '0;
         req  <= 1'b0;
         flag <= 1'b0;
      end else if (clr) begin
         cnt <= '0;
         req <= 1'b0;
      end else if (cnt >= lim_m1) begin
         cnt  <= '0;
         req  <= 1'b1;
         flag <= 1'b1;
      end else begin
         cnt <= cnt + 1'b1;
         req <= 1'b0;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!por_n)
      cnt <= LONG_M1); // R4
   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!por_n)
      clr |=> (cnt == '0)); // R1
   AST_REQ_ONE: assert property (@(posedge clk) disable iff (!por_n)
      req |=> !req); // R5
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      flag |=> flag); // R6
   AST_REQ_FLAG: assert property (@(posedge clk) disable iff (!por_n)
      req |-> flag); // R6
endmodule

// File: rtl/watchdog_guard.sv
module watchdog_guard
   import wdg_pkg::*;
#(
   parameter int unsigned LONG_LEN  = 262128,
   parameter int unsigned SHORT_LEN = 8176,
   parameter bit          RD_REG    = 1'b0
)(
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   input  logic [BUS_DW-1:0] vec_lo,
   input  logic              rate_sel,
   input  logic              mon_mode,
   input  logic              tst_volt,
   input  logic              wait_mode,
   input  logic              stop_mode,
   input  logic              brk_act,
   input  logic              brk_dis,
   output logic              wdg_rst_req,
   output logic              wdg_rst_flag
);
   generate
      if (SHORT_LEN < 2 || SHORT_LEN > LONG_LEN) begin : g_bad_len
         $error("watchdog_guard: need 2 <= SHORT_LEN <= LONG_LEN");
      end
   endgenerate

   wdg_mode_t mode;
   logic      svc;
   logic      off;
   logic      clr;
   logic      unused_wdata;

   assign mode = '{mon: mon_mode, tst: tst_volt, wt: wait_mode,
                   stp: stop_mode, brk: brk_act, bdis: brk_dis};
   assign unused_wdata = ^bus_wdata;

   wdg_bus #(.AW(BUS_AW), .DW(BUS_DW), .ADDR(SVC_ADDR), .RD_REG(RD_REG)) u_bus (
      .clk(clk), .por_n(por_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
      .vec(vec_lo), .rdata(bus_rdata), .svc(svc));

   wdg_gate u_gate (
      .mode(mode), .sys_rst(sys_rst), .svc(svc), .off(off), .clr(clr));

   wdg_count #(.LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN)) u_cnt (
      .clk(clk), .por_n(por_n), .clr(clr), .rate_sel(rate_sel),
      .req(wdg_rst_req), .flag(wdg_rst_flag));

   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!por_n)
      off |=> !wdg_rst_req); // R10
   AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!por_n)
      stop_mode |=> !wdg_rst_req); // R9
   AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!por_n)
      sys_rst |=> !wdg_rst_req); // R7
endmodule

// File: tb/sim_watchdog_guard.sv
`timescale 1ns/1ps
module sim_watchdog_guard;
   localparam int unsigned LONG  = 200;
   localparam int unsigned SHORT = 40;

   logic clk = 1'b0;
   logic por_n = 1'b0, sys_rst = 1'b0;
   logic [15:0] bus_addr = 16'h0000;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'h00, bus_rdata, vec_lo = 8'h00;
   logic rate_sel = 1'b0, mon_mode = 1'b0, tst_volt = 1'b0, wait_mode = 1'b0;
   logic stop_mode = 1'b0, brk_act = 1'b0, brk_dis = 1'b0;
   logic wdg_rst_req, wdg_rst_flag;

   int checks = 0, errors = 0;
   int mcnt = 0;
   logic mreq = 1'b0, mflag = 1'b0;
   string tag = "R7";

   always #4 clk = ~clk;

   watchdog_guard #(.LONG_LEN(LONG), .SHORT_LEN(SHORT)) u0 (.*);

   function automatic logic [7:0] exp_rdata(logic rd, logic [15:0] a, logic [7:0] v);
      return (rd && a == 16'hFFFF) ? v : 8'h00;
   endfunction

   task automatic chk(string t, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
      end
   endtask

   task automatic model_edge();
      logic svc, off, clr;
      int lim;
      if (!por_n) begin
         mcnt = 0; mreq = 1'b0; mflag = 1'b0;
         return;
      end
      svc = bus_wr && bus_addr == 16'hFFFF;
      off = (mon_mode && tst_volt) || (brk_act && mon_mode && brk_dis);
      clr = svc || off || stop_mode || sys_rst;
      lim = rate_sel ? SHORT : LONG;
      if (clr) begin mcnt = 0; mreq = 1'b0; end
      else if (mcnt >= lim - 1) begin mcnt = 0; mreq = 1'b1; mflag = 1'b1; end
      else begin mcnt++; mreq = 1'b0; end
   endtask

   task automatic tick(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         model_edge();
         #1;
         chk(tag, "req", wdg_rst_req, mreq);
         chk(tag, "flag", wdg_rst_flag, mflag);
         chk(tag, "rdata", bus_rdata, exp_rdata(bus_rd, bus_addr, vec_lo));
      end
   endtask

   task automatic bus_write(logic [15:0] a, logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      tick(1);
      bus_wr = 1'b0; bus_addr = 16'h0000;
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int unsigned r;
      r = $urandom(32'd4711);
      tag = "R7";
      tick(3);
      por_n = 1'b1;
      #1;
      chk("R7", "req after por", wdg_rst_req, 0);
      chk("R7", "flag after por", wdg_rst_flag, 0);
      // R4 long period, then short period from a fresh service
      tag = "R4"; rate_sel = 1'b0; tick(LONG + 5);
      rate_sel = 1'b1; bus_write(16'hFFFF, 8'h3C); tick(SHORT + 5);
      // R1 service mid-count postpones the timeout
      tag = "R1"; tick(30); bus_write(16'hFFFF, 8'h00); tick(30);
      bus_write(16'hFFFF, 8'hFF); tick(SHORT + 3);
      // R2 wrong-address writes change nothing
      tag = "R2"; bus_write(16'hFFFF, 8'h11); tick(20);
      bus_write(16'hFFFE, 8'h55); bus_write(16'h7FFF, 8'hAA); tick(SHORT);
      // R3 reads: vector byte at the service address, zero elsewhere
      tag = "R3"; vec_lo = 8'hA5; bus_rd = 1'b1; bus_addr = 16'hFFFF;
      #1; chk("R3", "rdata at svc addr", bus_rdata, 8'hA5);
      tick(SHORT + 2);
      bus_addr = 16'h1234; #1; chk("R3", "rdata other addr", bus_rdata, 8'h00);
      bus_rd = 1'b0; bus_addr = 16'h0000;
      // R8 wait keeps counting
      tag = "R8"; wait_mode = 1'b1; bus_write(16'hFFFF, 8'h01); tick(SHORT + 3);
      wait_mode = 1'b0;
      // R9 stop holds the count at zero
      tag = "R9"; tick(20); stop_mode = 1'b1; tick(SHORT + 20);
      stop_mode = 1'b0; tick(SHORT + 3);
      // R10 monitor with test voltage disables; either alone does not
      tag = "R10"; tick(10); mon_mode = 1'b1; tst_volt = 1'b1; tick(SHORT + 20);
      tst_volt = 1'b0; tick(SHORT + 3); mon_mode = 1'b0; tst_volt = 1'b1; tick(SHORT + 3);
      tst_volt = 1'b0;
      // R11 break with disable bit in monitor mode
      tag = "R11"; mon_mode = 1'b1; brk_act = 1'b1; brk_dis = 1'b1; tick(SHORT + 20);
      brk_dis = 1'b0; tick(SHORT + 3); brk_act = 1'b0; mon_mode = 1'b0;
      // R7 system reset clears count, R6 flag survives it
      tag = "R7"; tick(25); sys_rst = 1'b1; tick(5); sys_rst = 1'b0; tick(SHORT + 3);
      tag = "R6"; chk("R6", "flag kept over sys_rst", wdg_rst_flag, 1);
      por_n = 1'b0; #1; chk("R6", "flag cleared by por", wdg_rst_flag, 0);
      tick(2); por_n = 1'b1; tick(3);
      // R5 random mix
      tag = "R5";
      for (int i = 0; i < 8000; i++) begin
         r = $urandom;
         bus_wr    = (r % 55) == 0;
         bus_addr  = (r[8:7] == 2'b00) ? 16'(r >> 10) : 16'hFFFF;
         bus_wdata = 8'(r >> 16);
         bus_rd    = r[20];
         vec_lo    = 8'(r >> 21);
         wait_mode = r[29];
         stop_mode = (r % 97) == 3;
         mon_mode  = (r % 13) < 2;
         tst_volt  = (r % 7) == 1;
         brk_act   = (r % 11) == 2;
         brk_dis   = r[30];
         sys_rst   = (r % 401) == 5;
         if ((r % 3001) == 7) por_n = 1'b0; else por_n = 1'b1;
         if ((i % 700) == 0) rate_sel = ~rate_sel;
         tick(1);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule